// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square matrices of signed operands, C = A x B, on a two-dimensional grid of multiply-accumulate cells. The default grid is 3x3. Each cell owns one element of the result and keeps its accumulator in place for the whole computation. Operands of A travel across the rows from left to right, and operands of B travel down the columns. Each of them advances one cell per clock through a register in every cell.

A host places both matrices on the flat input buses and pulses `start`. That edge stores both matrices inside the block and clears every accumulator. The edge feeders then release the operands on a staggered schedule. Row i receives A[i][k] in step i+k+1, and column j receives B[k][j] in step j+k+1. This timing makes cell (i,j) add the term a[i][k]*b[k][j] in step i+j+k+1, with the terms taken in the order k = 0, 1, 2. The final term reaches the bottom-right cell in step 3N-2, which is 7 for N = 3. The block then pulses `done` for one cycle. The nine results remain on `c_mat` until the next `start`.

Top module: `sysmm_top`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block resets synchronously. Afterwards `done` and `busy` are 0 and every field of `c_mat` is 0.
- R2: A clock edge that samples `start` high does two things. It stores `a_mat` and `b_mat`, and it clears all accumulators. In the next cycle every field of `c_mat` is 0 and `busy` is 1.
- R3: At `done`, field (i,j) of `c_mat` holds the exact signed value of the sum over k of A[i][k]*B[k][j]. Field (i,j) is `c_mat[(i*N+j)*ACC_W +: ACC_W]`, with ACC_W = 18 by default. Element A[i][k] is `a_mat[(i*N+k)*8 +: 8]` and element B[k][j] is `b_mat[(k*N+j)*8 +: 8]`. All fields are two's complement.
- R4: `done` goes high for exactly one cycle, in the cycle that follows the 3N-2 = 7th step after the start edge. It is 0 in every other cycle.
- R5: `busy` is 1 in steps 1 through 3N-2 after a start edge, and it is 0 in the cycle in which `done` is high.
- R6: Results stay unchanged from `done` until the next `start`. A change to `a_mat` or `b_mat` after the start edge has no effect on any result.
- R7: If `start` arrives while a computation is running, the running computation is abandoned. The new operands are used, and `done` comes 3N-2 steps after the new start edge.
- R8: Accumulators never overflow. With every operand at -128, each result is 49152. With A all -128 and B all 127, each result is -48768.
- R9: After step t, field (i,j) holds the partial sum of the terms whose k satisfies i+j+k+1 <= t. In particular, after step 1 only cell (0,0) can be nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Stores the operands, clears the accumulators and begins the schedule |
| a_mat | input | N*N*8 | Matrix A, row-major, signed 8-bit elements |
| b_mat | input | N*N*8 | Matrix B, row-major, signed 8-bit elements |
| done | output | 1 | One-cycle pulse when the product is complete |
| busy | output | 1 | High while the schedule is running |
| c_mat | output | N*N*ACC_W | Matrix C, row-major, signed accumulators |

## Verification
The assertions check several timing properties on every cycle. `done` is a single-cycle pulse that comes exactly 3N-2 busy cycles after the latest start. `busy` is low during `done`. Accumulators read zero right after a start, and the results do not move while the block is idle. These properties do not show that the numbers are right. Only the bench scenarios can show that operands meet in the correct cell and in the correct order. The bench checks every partial sum against the schedule after every step. It also checks signed extremes, a restart in the middle of a run, and that input changes after the start edge are ignored.

// File: rtl/sysmm_pkg.sv
// Package sysmm_pkg
// Shared sizing helpers for the systolic multiplier.
// Assumes N >= 2 and W >= 2.
package sysmm_pkg;

    // ceil(log2(v)); returns 1 for v <= 2
    function automatic int clog2i(input int v);
        int r;
        r = 1;
        while ((1 << r) < v) r++;
        return r;
    endfunction

    // Accumulator width that holds N products of two W-bit signed values
    function automatic int acc_width(input int w, input int n);
        return 2 * w + clog2i(n);
    endfunction

    // Number of schedule steps in one multiplication (3N-2)
    function automatic int last_step(input int n);
        return 3 * n - 2;
    endfunction

endpackage

// File: rtl/sysmm_ctrl.sv
// Module sysmm_ctrl
// Step sequencer. A start pulse sets the step to 1 and raises busy.
// Each busy cycle advances the step. After the final step (3N-2),
// busy drops and done pulses for one cycle. A start always takes
// priority over a running schedule.
module sysmm_ctrl #(
    parameter int N  = 3,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [CW-1:0] step,
    output logic          busy,
    output logic          done
);
    localparam int LAST = sysmm_pkg::last_step(N);

    // Step counter, busy and done flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else if (start) begin
            step <= CW'(1);
            busy <= 1'b1;
            done <= 1'b0;
        end else if (busy) begin
            if (int'(step) == LAST) begin
                step <= '0;
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                step <= step + CW'(1);
                done <= 1'b0;
            end
        end else begin
            done <= 1'b0;
        end
    end
endmodule

// File: rtl/sysmm_skew.sv
// Module sysmm_skew
// Edge feeder for one side of the array. It stores an NxN operand
// matrix in lane-major order: element k of lane l sits at
// (l*N+k)*W. In step l+k+1 it presents element k of lane l
// together with a valid bit. In every other step the lane carries
// zero with valid low.
module sysmm_skew #(
    parameter int N  = 3,
    parameter int W  = 8,
    parameter int CW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N*N*W-1:0] mat_in,
    input  logic [CW-1:0]  step,
    input  logic           busy,
    output logic [N*W-1:0] lane_val,
    output logic [N-1:0]   lane_vld
);
    logic [N*N*W-1:0] store;

    // Store the operand matrix on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (load) begin
            store <= mat_in;
        end
    end

    // Pick the element whose skewed slot matches the current step
    always_comb begin
        lane_val = '0;
        lane_vld = '0;
        for (int l = 0; l < N; l++) begin
            for (int k = 0; k < N; k++) begin
                if (busy && (int'(step) == l + k + 1)) begin
                    lane_val[l*W +: W] = store[(l*N+k)*W +: W];
                    lane_vld[l]        = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sysmm_cell.sv
// Module sysmm_cell
// One processing element. When both incoming operands are valid,
// it adds their signed product to a local accumulator that stays
// in place. It forwards each operand and its valid bit through one
// register stage, A to the right and B downward. Clear zeroes all
// of its state. Assumes ACC_W > 2*W.
module sysmm_cell #(
    parameter int W     = 8,
    parameter int ACC_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic signed [W-1:0]     a_in,
    input  logic                    a_vin,
    input  logic signed [W-1:0]     b_in,
    input  logic                    b_vin,
    output logic signed [W-1:0]     a_out,
    output logic                    a_vout,
    output logic signed [W-1:0]     b_out,
    output logic                    b_vout,
    output logic signed [ACC_W-1:0] acc
);
    logic signed [2*W-1:0]   prod;
    logic signed [ACC_W-1:0] prod_ext;

    // Signed product, sign-extended to the accumulator width
    always_comb begin
        prod     = a_in * b_in;
        prod_ext = $signed({{(ACC_W-2*W){prod[2*W-1]}}, prod});
    end

    // Operand forwarding registers and accumulator
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            a_out  <= '0;
            a_vout <= 1'b0;
            b_out  <= '0;
            b_vout <= 1'b0;
            acc    <= '0;
        end else begin
            a_out  <= a_in;
            a_vout <= a_vin;
            b_out  <= b_in;
            b_vout <= b_vin;
            if (a_vin && b_vin) begin
                acc <= acc + prod_ext;
            end
        end
    end
endmodule

// File: rtl/sysmm_top.sv
// Module sysmm_top
// NxN output-stationary systolic multiplier, C = A x B. Both
// matrices are row-major with signed W-bit elements, and they are
// stored at start. Feeders on the left and top edges skew the
// operands in time. Cell (i,j) builds C[i][j] in place. The result
// fields are row-major, each ACC_W bits wide.
module sysmm_top #(
    parameter int N = 3,
    parameter int W = 8,
    localparam int ACC_W = sysmm_pkg::acc_width(W, N),
    localparam int CW    = sysmm_pkg::clog2i(3 * N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [N*N*W-1:0]     a_mat,
    input  logic [N*N*W-1:0]     b_mat,
    output logic                 done,
    output logic                 busy,
    output logic [N*N*ACC_W-1:0] c_mat
);
    logic [CW-1:0]    step;
    logic [N*N*W-1:0] b_lane_major;
    logic [N*W-1:0]   a_lane, b_lane;
    logic [N-1:0]     a_lvld, b_lvld;

    logic signed [W-1:0]     a_bus [N][N+1];
    logic                    a_vb  [N][N+1];
    logic signed [W-1:0]     b_bus [N+1][N];
    logic                    b_vb  [N+1][N];
    logic signed [ACC_W-1:0] acc_w [N][N];

    sysmm_ctrl #(.N(N), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .step(step), .busy(busy), .done(done)
    );

    // Reorder B so that each column becomes one feeder lane
    for (genvar j = 0; j < N; j++) begin : g_bcol
        for (genvar k = 0; k < N; k++) begin : g_bk
            assign b_lane_major[(j*N+k)*W +: W] = b_mat[(k*N+j)*W +: W];
        end
    end

    sysmm_skew #(.N(N), .W(W), .CW(CW)) u_skew_a (
        .clk(clk), .rst_n(rst_n), .load(start), .mat_in(a_mat),
        .step(step), .busy(busy), .lane_val(a_lane), .lane_vld(a_lvld)
    );

    sysmm_skew #(.N(N), .W(W), .CW(CW)) u_skew_b (
        .clk(clk), .rst_n(rst_n), .load(start), .mat_in(b_lane_major),
        .step(step), .busy(busy), .lane_val(b_lane), .lane_vld(b_lvld)
    );

    // Edge feeds into the first column and the first row
    for (genvar e = 0; e < N; e++) begin : g_edge
        assign a_bus[e][0] = $signed(a_lane[e*W +: W]);
        assign a_vb[e][0]  = a_lvld[e];
        assign b_bus[0][e] = $signed(b_lane[e*W +: W]);
        assign b_vb[0][e]  = b_lvld[e];
    end

    // Cell grid and result packing
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            sysmm_cell #(.W(W), .ACC_W(ACC_W)) u_cell (
                .clk(clk), .rst_n(rst_n), .clear(start),
                .a_in(a_bus[i][j]),   .a_vin(a_vb[i][j]),
                .b_in(b_bus[i][j]),   .b_vin(b_vb[i][j]),
                .a_out(a_bus[i][j+1]), .a_vout(a_vb[i][j+1]),
                .b_out(b_bus[i+1][j]), .b_vout(b_vb[i+1][j]),
                .acc(acc_w[i][j])
            );
            assign c_mat[(i*N+j)*ACC_W +: ACC_W] = acc_w[i][j];
        end
    end
endmodule

// File: rtl/sysmm_chk.sv
// Module sysmm_chk
// Timing checker bound to sysmm_top. It counts the busy cycles
// since the most recent start and relates done, busy and the
// result bus to that count.
module sysmm_chk #(
    parameter int N     = 3,
    parameter int ACC_W = 18
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 done,
    input logic                 busy,
    input logic [N*N*ACC_W-1:0] c_mat
);
    localparam int LAST = 3 * N - 2;
    int run_len;

    // Busy cycles since the latest start
    always_ff @(posedge clk) begin
        if (!rst_n || start) run_len <= 0;
        else if (busy) run_len <= run_len + 1;
    end

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_schedule: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LAST));

    a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r5_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && (c_mat == '0)));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(c_mat));
endmodule

bind sysmm_top sysmm_chk #(.N(N), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .busy(busy), .c_mat(c_mat)
);

// File: tb/sysmm_top_test.sv
// Bench for sysmm_top with the default parameters (N=3, W=8, ACC_W=18)
module sysmm_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int ACC = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*N*8-1:0]   a_mat = '0;
    logic [N*N*8-1:0]   b_mat = '0;
    logic done, busy;
    logic [N*N*ACC-1:0] c_mat;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;
    int ma [N][N];
    int mb [N][N];

    sysmm_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_mat(a_mat),
        .b_mat(b_mat), .done(done), .busy(busy), .c_mat(c_mat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int get_c(input int i, input int j);
        return int'($signed(c_mat[(i*N+j)*ACC +: ACC]));
    endfunction

    // Partial sum expected after step t (R9); with t >= 3N-2 it is the full product (R3)
    function automatic int part(input int i, input int j, input int t);
        int s = 0;
        for (int k = 0; k < N; k++)
            if (i + j + k + 1 <= t) s += ma[i][k] * mb[k][j];
        return s;
    endfunction

    task automatic pack();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                a_mat[(i*N+k)*8 +: 8] = 8'(ma[i][k]);
                b_mat[(i*N+k)*8 +: 8] = 8'(mb[i][k]);
            end
    endtask

    task automatic rand_mats();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = int'($urandom_range(255)) - 128;
                mb[i][k] = int'($urandom_range(255)) - 128;
            end
        pack();
    endtask

    task automatic fill(input int va, input int vb);
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = va;
                mb[i][k] = vb;
            end
        pack();
    endtask

    // Pulse start from a negedge and check the cleared state (R2)
    task automatic launch();
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                check(get_c(i, j) == 0, "R2 clear", get_c(i, j), 0);
        check(busy == 1'b1, "R5 busy after start", int'(busy), 1);
    endtask

    // Follow steps 1..7, checking partial sums, done and busy. If
    // scramble is set, the inputs are changed mid-run (R6).
    task automatic follow(input string tag, input bit scramble);
        for (int t = 1; t <= 3*N-2; t++) begin
            @(posedge clk);
            @(negedge clk);
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    check(get_c(i, j) == part(i, j, t),
                          (t == 3*N-2) ? {"R3 product ", tag} : {"R9 partial ", tag},
                          get_c(i, j), part(i, j, t));
            check(done == (t == 3*N-2), "R4 done timing", int'(done), int'(t == 3*N-2));
            check(busy == (t < 3*N-2), "R5 busy window", int'(busy), int'(t < 3*N-2));
            if (scramble && t == 2) begin
                a_mat = ~a_mat;
                b_mat = {b_mat[7:0], b_mat[N*N*8-1:8]};
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R4 done single pulse", int'(done), 0);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = int'($urandom(32'd20240611));
        // Reset (R1)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 reset done", int'(done), 0);
        check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        check(c_mat == '0, "R1 reset results", int'(c_mat[ACC-1:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: A = identity-like pattern, B = 1..9
        for (int i = 0; i < N; i++)
            for (int k = 0; k < N; k++) begin
                ma[i][k] = (i == k) ? 1 : 0;
                mb[i][k] = i * N + k + 1;
            end
        pack();
        launch();
        follow("identity", 1'b0);

        // Extremes (R8)
        fill(-128, -128);
        launch();
        follow("R8 min*min", 1'b0);
        check(get_c(2, 2) == 49152, "R8 min*min", get_c(2, 2), 49152);
        fill(-128, 127);
        launch();
        follow("R8 min*max", 1'b0);
        check(get_c(1, 0) == -48768, "R8 min*max", get_c(1, 0), -48768);

        // Random runs; the first scrambles the inputs mid-run (R6)
        for (int r = 0; r < 6; r++) begin
            rand_mats();
            launch();
            follow("random", r == 0);
        end

        // Hold after done while inputs change (R6)
        a_mat = ~a_mat;
        b_mat = ~b_mat;
        repeat (5) @(negedge clk);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                check(get_c(i, j) == part(i, j, 3*N-2), "R6 hold", get_c(i, j), part(i, j, 3*N-2));

        // Restart mid-run (R7)
        rand_mats();
        launch();
        repeat (3) begin
            @(posedge clk);
            @(negedge clk);
        end
        rand_mats();
        launch();
        follow("R7 restart", 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule